// File: doc/BRIEF.md
# ACPI power-management event controller

This block holds the fixed power-management registers of a PC chipset: a free-running power-management timer, a status register, an enable register and a control register. Software reaches them over a simple word-wide register bus. A status bit that is both set and enabled raises the level-sensitive system control interrupt (SCI).

The timer advances by one on each cycle where the tick enable input is high. That enable is meant to pulse at 3,579,545 Hz. Each time the timer count passes a multiple of half its range, the timer-overflow status bit is set. A power-button input and an APM command byte can change state inside the block. A write to the control register can ask for a soft power-off or for a suspend with resume. The block only flags these requests with one-cycle pulses and does not act on them.

The timer width is the parameter `TMR_W`, which defaults to 24. The overflow point is therefore every 0x800000 counts, each time bit 23 changes.

Top module: `pm_event_ctrl`

Register addresses on `reg_addr`: 0 = status, 1 = enable, 2 = control, 3 = timer (read-only).

Status bits:
- Bit 0: timer overflow.
- Bit 8: power button.
- Bit 15: resume.

Enable bits that take part in the SCI:
- Bit 0: timer overflow.
- Bit 5: global.
- Bit 8: power button.
- Bit 10: RTC.

Control bits:
- Bit 0: SCI enable.
- Bits 12:10: sleep type.
- Bit 13: sleep trigger.

## Requirements
- R1: After reset, every register reads 0, the timer reads 0, and `sci`, `off_req` and `wake_req` are low.
- R2: The timer increments by one in each cycle where `tick` is high and holds otherwise. A read at address 3 returns the `TMR_W`-bit count zero-extended to 32 bits.
- R3: Status bit 0 is set when a tick moves the timer across a multiple of 2^(TMR_W-1), that is, when bit TMR_W-1 of the count toggles. This includes the wrap from all ones to zero. No other tick sets it.
- R4: Status bits are write-one-to-clear. Writing 1 clears the bit, and writing 0 leaves it unchanged. A set event in the same cycle as the clearing write wins, so the bit stays set.
- R5: The enable register reads back what was written. `sci` is high exactly while (status & enable & 0x0521) is nonzero.
- R6: A cycle with `pwr_btn` high sets status bit 8 only if enable bit 8 is set. Otherwise status is unchanged.
- R7: A control write stores every bit except bit 13. Bit 13 always reads 0.
- R8: A control write with bit 13 set and bits 12:10 equal to 0 pulses `off_req` high for exactly one cycle, starting the cycle after the write.
- R9: A control write with bit 13 set and bits 12:10 equal to 1 does three things starting the cycle after the write: it sets status bits 15 and 8 regardless of the enable register, and it pulses `wake_req` for one cycle.
- R10: An accepted APM command 0xF1 sets control bit 0, and 0xF0 clears it. Any other command code leaves control unchanged. If a control write happens in the same cycle, the written value wins.
- R11: A control write with bit 13 set and any other sleep type raises neither request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timer advance enable, one cycle per timer period |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 status, 1 enable, 2 control, 3 timer |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| pwr_btn | input | 1 | Power-button press, one cycle |
| apm_valid | input | 1 | APM command byte is valid |
| apm_cmd | input | 8 | APM command byte |
| sci | output | 1 | System control interrupt, level |
| off_req | output | 1 | Soft power-off request pulse |
| wake_req | output | 1 | Suspend-with-resume (reset) request pulse |

## Verification
The hardest situation to reach is the timer crossing its overflow boundary in the same cycle that software clears the overflow bit. Also hard to reach is the wrap of the timer back to zero, which must set the bit a second time. At the default width both need millions of ticks. The bench therefore builds the block with an 8-bit timer so that both boundaries fall within a few hundred ticks. It lines up a status write with the tick that reaches the boundary to check that the set event wins.

// File: rtl/pm_event_ctrl.sv
module pm_event_ctrl #(
  parameter int TMR_W = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        pwr_btn,
  input  logic        apm_valid,
  input  logic [7:0]  apm_cmd,
  output logic        sci,
  output logic        off_req,
  output logic        wake_req
);
  localparam logic [15:0] STS_BITS = 16'h8101;
  localparam logic [15:0] SCI_MASK = 16'h0521;
  localparam logic [15:0] SLP_TRIG = 16'h2000;

  logic [TMR_W-1:0] tmr;
  logic [15:0] sts, en, ctl;

  wire sts_wr   = reg_we && reg_addr == 2'd0;
  wire en_wr    = reg_we && reg_addr == 2'd1;
  wire ctl_wr   = reg_we && reg_addr == 2'd2;
  wire slp_go   = ctl_wr && reg_wdata[13];
  wire slp_off  = slp_go && reg_wdata[12:10] == 3'd0;
  wire slp_rsm  = slp_go && reg_wdata[12:10] == 3'd1;
  wire ovf_evt  = tick && (&tmr[TMR_W-2:0]);
  wire btn_evt  = pwr_btn && en[8];

  wire [15:0] sts_set = {slp_rsm, 6'd0, btn_evt | slp_rsm, 7'd0, ovf_evt};
  wire [15:0] sts_clr = sts_wr ? reg_wdata : 16'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmr      <= '0;
      sts      <= '0;
      en       <= '0;
      ctl      <= '0;
      off_req  <= 1'b0;
      wake_req <= 1'b0;
    end else begin
      if (tick) tmr <= tmr + 1'b1;
      sts <= ((sts & ~sts_clr) | sts_set) & STS_BITS;
      if (en_wr) en <= reg_wdata;
      if (ctl_wr) ctl <= reg_wdata & ~SLP_TRIG;
      else if (apm_valid && apm_cmd == 8'hF1) ctl[0] <= 1'b1;
      else if (apm_valid && apm_cmd == 8'hF0) ctl[0] <= 1'b0;
      off_req  <= slp_off;
      wake_req <= slp_rsm;
    end
  end

  assign sci = |(sts & en & SCI_MASK);

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {16'd0, sts};
      2'd1:    reg_rdata = {16'd0, en};
      2'd2:    reg_rdata = {16'd0, ctl};
      default: reg_rdata = 32'(tmr);
    endcase
  end

  AST_TMR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> tmr == $past(tmr) + 1'b1); // R2
  AST_TMR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(tmr)); // R2
  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (&tmr[TMR_W-2:0])) |=> sts[0]); // R3
  AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_wr && reg_wdata[0] && !(tick && (&tmr[TMR_W-2:0]))) |=> !sts[0]); // R4
  AST_BTN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_btn && !en[8] && !sts_wr && !slp_go) |=> sts[8] == $past(sts[8])); // R6
  AST_OFF_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    off_req |=> !off_req); // R8
  AST_RSM_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && reg_wdata[13] && reg_wdata[12:10] == 3'd1) |=> wake_req && sts[15] && sts[8]); // R9
  AST_APM_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (apm_valid && apm_cmd == 8'hF1 && !ctl_wr) |=> ctl[0]); // R10
  AST_NO_TRIG_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> !ctl[13]); // R7
endmodule

// File: tb/test_pm_event_ctrl.sv
module test_pm_event_ctrl;
  localparam int CLK_P = 10;
  localparam int TW = 8;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [31:0] reg_rdata;
  logic pwr_btn = 1'b0, apm_valid = 1'b0;
  logic [7:0] apm_cmd = 8'd0;
  logic sci, off_req, wake_req;

  pm_event_ctrl #(.TMR_W(TW)) i_pm_event_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwr_btn(pwr_btn),
    .apm_valid(apm_valid), .apm_cmd(apm_cmd), .sci(sci), .off_req(off_req),
    .wake_req(wake_req));

  always #(CLK_P/2) clk = ~clk;

  typedef struct {
    bit          is_out;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always begin
    @(negedge clk);
    #(CLK_P/4);
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      act = it.is_out ? {29'd0, sci, off_req, wake_req} : reg_rdata;
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic exp_rd(input logic [1:0] a, input logic [31:0] e, input string tag);
    item_t it;
    reg_addr = a;
    it.is_out = 1'b0; it.exp = e; it.tag = tag;
    q.push_back(it);
    @(negedge clk);
  endtask

  task automatic exp_out(input logic s, input logic o, input logic w, input string tag);
    item_t it;
    it.is_out = 1'b1; it.exp = {29'd0, s, o, w}; it.tag = tag;
    q.push_back(it);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic ticks(input int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic apm(input logic [7:0] c);
    apm_valid = 1'b1; apm_cmd = c;
    @(negedge clk);
    apm_valid = 1'b0;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    exp_rd(2'd0, 32'h0, "R1 status");
    exp_rd(2'd1, 32'h0, "R1 enable");
    exp_rd(2'd2, 32'h0, "R1 control");
    exp_rd(2'd3, 32'h0, "R1 timer");
    exp_out(1'b0, 1'b0, 1'b0, "R1 outputs");

    ticks(5);
    exp_rd(2'd3, 32'h5, "R2 count");
    repeat (3) @(negedge clk);
    exp_rd(2'd3, 32'h5, "R2 hold");
    ticks(122);
    exp_rd(2'd3, 32'h7F, "R2 at 127");
    exp_rd(2'd0, 32'h0, "R3 before boundary");
    ticks(1);
    exp_rd(2'd3, 32'h80, "R2 zero-extended");
    exp_rd(2'd0, 32'h1, "R3 boundary 128");

    wr(2'd1, 16'h0001);
    exp_rd(2'd1, 32'h1, "R5 enable readback");
    exp_out(1'b1, 1'b0, 1'b0, "R5 sci on overflow");
    wr(2'd0, 16'h0000);
    exp_rd(2'd0, 32'h1, "R4 write 0 keeps");
    wr(2'd0, 16'h0001);
    exp_rd(2'd0, 32'h0, "R4 write 1 clears");
    exp_out(1'b0, 1'b0, 1'b0, "R5 sci drops");

    ticks(127);
    exp_rd(2'd0, 32'h0, "R3 no set at 255");
    ticks(1);
    exp_rd(2'd3, 32'h0, "R2 wrap");
    exp_rd(2'd0, 32'h1, "R3 wrap sets");
    wr(2'd0, 16'h0001);

    pwr_btn = 1'b1; @(negedge clk); pwr_btn = 1'b0;
    exp_rd(2'd0, 32'h0, "R6 masked press");
    wr(2'd1, 16'h0100);
    pwr_btn = 1'b1; @(negedge clk); pwr_btn = 1'b0;
    exp_rd(2'd0, 32'h100, "R6 enabled press");
    exp_out(1'b1, 1'b0, 1'b0, "R5 sci from button");
    wr(2'd0, 16'h0100);

    wr(2'd2, 16'h2C01);
    exp_out(1'b0, 1'b0, 1'b0, "R11 type 3 no request");
    exp_rd(2'd2, 32'h0C01, "R7 trigger not stored");
    wr(2'd2, 16'h2000);
    exp_out(1'b0, 1'b1, 1'b0, "R8 off pulse");
    exp_out(1'b0, 1'b0, 1'b0, "R8 pulse ends");
    exp_rd(2'd2, 32'h0, "R7 reads zero");

    wr(2'd1, 16'h0000);
    wr(2'd2, 16'h2400);
    exp_out(1'b0, 1'b0, 1'b1, "R9 wake pulse");
    exp_rd(2'd0, 32'h8100, "R9 resume flags");
    exp_out(1'b0, 1'b0, 1'b0, "R9 pulse ends");

    apm(8'hF1);
    exp_rd(2'd2, 32'h0401, "R10 F1 sets");
    apm(8'h55);
    exp_rd(2'd2, 32'h0401, "R10 other ignored");
    apm(8'hF0);
    exp_rd(2'd2, 32'h0400, "R10 F0 clears");

    ticks(127);
    tick = 1'b1; reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 16'h0001;
    @(negedge clk);
    tick = 1'b0; reg_we = 1'b0;
    exp_rd(2'd0, 32'h8101, "R4 set beats clear");

    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule